// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is an 18-bit first-in-first-out buffer. The writer and the reader each have their own clock, and the two clocks are not related. The writer pushes a word on each write-clock edge where the write enable is high. The reader pops words on read-clock edges. There are two read-timing modes. In standard mode a word reaches the output only after a read request. In first-word-fall-through mode the oldest word is placed on the output without any request, and a read enable consumes that word.

The block reports an empty or output-valid flag, a full or room-available flag, a half-full flag and two threshold flags. The threshold flags compare the fill level with two offset registers. Those registers are set at master reset to one of two presets, and can later be reloaded word-wise from the data bus or bit-wise from a serial input. A partial reset empties the buffer and keeps the offsets and the mode. A retransmit input rewinds the reader to the first location, so the stored words can be replayed.

The depth is 2^ADDR_W words (2048 by default). Both resets are synchronous and must be held for at least three edges of each clock. The fill level is the number of words held in the storage array. In fall-through mode, the word already presented on the output is not part of that count.

Top module: `dual_clk_fifo`

## Requirements
- R1: Master reset (mrst high) empties the buffer and sets dataOut to 0. It samples fwftSel (0 standard, 1 fall-through) and offSel (0 gives 127, 1 gives 1023 for both offsets). After release: halfFull=0, almostFull=0, almostEmpty=1. Standard mode gives emptyOrRdy=1 and fullOrIrdy=0. Fall-through mode gives emptyOrRdy=0 and fullOrIrdy=1.
- R2: In standard mode, words come out in the order they were written. dataOut changes at the read-clock edge that samples ren high while a word is stored. emptyOrRdy is 1 exactly when no word is stored.
- R3: A write while the buffer holds DEPTH words is dropped, and a read while it is empty leaves dataOut unchanged. In both cases no pointer moves.
- R4: In standard mode, fullOrIrdy is 1 exactly when DEPTH words are stored, as counted in the write domain.
- R5: halfFull is 1 when the write-domain fill level is greater than DEPTH/2.
- R6: almostEmpty is 1 when the read-domain fill level is at most the empty offset. almostFull is 1 when the write-domain fill level is at least DEPTH minus the full offset.
- R7: In fall-through mode the oldest word appears on dataOut with no ren, and emptyOrRdy=1 marks it as valid. A ren pulse replaces it with the next word, or clears emptyOrRdy if none is stored. fullOrIrdy=1 while a write would be accepted.
- R8: Partial reset (prst high) empties the buffer but keeps both offsets and the read mode. It ignores fwftSel and offSel.
- R9: While ld is high, successive write-enabled cycles load dataIn[ADDR_W-1:0] into the empty offset first, then into the full offset, alternating. Nothing is written to the buffer. The order restarts whenever ld is low.
- R10: While ld and sen are high, each write-clock edge shifts serIn into the offsets, least significant bit first. The empty offset fills first, then the full offset, ADDR_W bits each.
- R11: A retransmit pulse (rt) moves the read pointer to location 0. Later reads return the words from the first one written after the last reset.
- R12: The write pointer and the read pointer cross domains as Gray codes and change by at most one bit per cycle, except on rewind. The fill level never exceeds DEPTH. A word written into an empty buffer is signalled on the read side within four read-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| mrst | input | 1 | Master reset, synchronous in both domains |
| prst | input | 1 | Partial reset, keeps offsets and mode |
| fwftSel | input | 1 | Read mode sampled at master reset (1 = fall-through) |
| offSel | input | 1 | Default offset choice sampled at master reset |
| wen | input | 1 | Write enable |
| dataIn | input | 18 | Write data, and parallel offset value |
| ld | input | 1 | Offset load control |
| sen | input | 1 | Serial offset shift enable |
| serIn | input | 1 | Serial offset bit |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit |
| dataOut | output | 18 | Read data register |
| emptyOrRdy | output | 1 | Empty (standard) or output valid (fall-through) |
| fullOrIrdy | output | 1 | Full (standard) or room available (fall-through) |
| halfFull | output | 1 | More than half the depth is stored |
| almostEmpty | output | 1 | Fill level at or below the empty offset |
| almostFull | output | 1 | Fill level within the full offset of DEPTH |

## Verification
On every cycle, assertions check that the fill level never exceeds DEPTH on either side. They also check that each Gray pointer steps by one bit, that a fall-through output word is dropped only after a read or rewind, and that a partial reset leaves the offsets alone. The bench scenarios show the rest: data order across the two clocks, each flag threshold at its exact count, overflow and underflow being ignored, the two offset load paths, replay after retransmit, and the first-word latency.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic wrStb;   // store dataIn at the write address
    logic rdLoad;  // load the output register from the read address
    logic outClr;  // clear the output register
  } fifoStb_t;
endpackage

// File: rtl/gray_sync.sv
`timescale 1ns/1ps
module gray_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      dOut <= '0;
    end else begin
      meta <= dIn;
      dOut <= meta;
    end
  end
endmodule

// File: rtl/dcfifo_ctrl.sv
`timescale 1ns/1ps
module dcfifo_ctrl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int OFF_DEF_LO = 127,
  parameter int OFF_DEF_HI = 1023
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              fwftSel,
  input  logic              offSel,
  input  logic              wen,
  input  logic [ADDR_W-1:0] offIn,
  input  logic              ld,
  input  logic              sen,
  input  logic              serIn,
  input  logic              ren,
  input  logic              rt,
  output fifoStb_t          stb,
  output logic [ADDR_W-1:0] wAddr,
  output logic [ADDR_W-1:0] rAddr,
  output logic              emptyOrRdy,
  output logic              fullOrIrdy,
  output logic              halfFull,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0]     DEPTH_V = PW'(DEPTH);
  localparam logic [PW-1:0]     HALF_V  = PW'(DEPTH / 2);
  localparam logic [ADDR_W-1:0] DEF_LO  = ADDR_W'(OFF_DEF_LO);
  localparam logic [ADDR_W-1:0] DEF_HI  = ADDR_W'(OFF_DEF_HI);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic wRst;
  assign wRst = mrst | prst;

  // ---------------- write domain ----------------
  logic [PW-1:0]     wBin, wGray, rGrayW, rBinW, wrCount;
  logic [ADDR_W-1:0] aeOff, afOff;
  logic              fwftW, ldIdx, wFull, wrGo;

  gray_sync #(.W(PW)) uRdToWr (.clk(wclk), .rst(wRst), .dIn(rGray), .dOut(rGrayW));

  assign rBinW   = fromGray(rGrayW);
  assign wrCount = wBin - rBinW;
  assign wFull   = (wrCount == DEPTH_V);
  assign wrGo    = wen && !ld && !wFull && !wRst;

  always_ff @(posedge wclk) begin
    if (wRst) begin
      wBin  <= '0;
      wGray <= '0;
    end else if (wrGo) begin
      wBin  <= wBin + PW'(1);
      wGray <= toGray(wBin + PW'(1));
    end
  end

  // Mode and offset settings; only master reset reinitialises them.
  always_ff @(posedge wclk) begin
    if (mrst) begin
      fwftW <= fwftSel;
      aeOff <= offSel ? DEF_HI : DEF_LO;
      afOff <= offSel ? DEF_HI : DEF_LO;
      ldIdx <= 1'b0;
    end else if (prst || !ld) begin
      ldIdx <= 1'b0;
    end else if (wen) begin
      if (!ldIdx) aeOff <= offIn;
      else        afOff <= offIn;
      ldIdx <= ~ldIdx;
    end else if (sen) begin
      {afOff, aeOff} <= {serIn, afOff, aeOff[ADDR_W-1:1]};
    end
  end

  assign fullOrIrdy = fwftW ? !wFull : wFull;
  assign halfFull   = (wrCount > HALF_V);
  assign almostFull = (wrCount >= (DEPTH_V - {1'b0, afOff}));

  // ---------------- read domain ----------------
  logic [PW-1:0] rBin, rGray, wGrayR, wBinR, rdCount;
  logic          fwftR, outValid, ramEmpty, rdGo;

  gray_sync #(.W(PW)) uWrToRd (.clk(rclk), .rst(wRst), .dIn(wGray), .dOut(wGrayR));

  assign wBinR    = fromGray(wGrayR);
  assign rdCount  = wBinR - rBin;
  assign ramEmpty = (rdCount == '0);
  assign rdGo     = !wRst && !rt && !ramEmpty && (fwftR ? (!outValid || ren) : ren);

  always_ff @(posedge rclk) begin
    if (mrst) fwftR <= fwftSel;
  end

  always_ff @(posedge rclk) begin
    if (wRst || rt) begin
      rBin     <= '0;
      rGray    <= '0;
      outValid <= 1'b0;
    end else begin
      if (rdGo) begin
        rBin  <= rBin + PW'(1);
        rGray <= toGray(rBin + PW'(1));
      end
      if (fwftR) begin
        if (rdGo)     outValid <= 1'b1;
        else if (ren) outValid <= 1'b0;
      end
    end
  end

  assign emptyOrRdy  = fwftR ? outValid : ramEmpty;
  assign almostEmpty = (rdCount <= {1'b0, aeOff});

  // ---------------- strobes to the datapath ----------------
  assign stb.wrStb  = wrGo;
  assign stb.rdLoad = rdGo;
  assign stb.outClr = wRst;
  assign wAddr      = wBin[ADDR_W-1:0];
  assign rAddr      = rBin[ADDR_W-1:0];

  // ---------------- assertions ----------------
  // R3
  wr_ovf_chk: assert property (@(posedge wclk) disable iff (wRst) wrCount <= DEPTH_V);
  // R12
  rd_cnt_chk: assert property (@(posedge rclk) disable iff (wRst) rdCount <= DEPTH_V);
  // R12
  wgray_step_chk: assert property (@(posedge wclk) disable iff (wRst)
    $countones(wGray ^ $past(wGray)) <= 1);
  // R12
  rgray_step_chk: assert property (@(posedge rclk) disable iff (wRst)
    !rt |=> $countones(rGray ^ $past(rGray)) <= 1);
  // R7
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (wRst)
    (fwftR && $fell(outValid)) |-> ($past(ren) || $past(rt)));
  // R8
  keep_off_chk: assert property (@(posedge wclk) disable iff (mrst)
    prst |=> ($stable(aeOff) && $stable(afOff)));
endmodule

// File: rtl/dcfifo_dpath.sv
`timescale 1ns/1ps
module dcfifo_dpath
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 11
) (
  input  logic              wclk,
  input  logic              rclk,
  input  fifoStb_t          stb,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (stb.wrStb) mem[wAddr] <= dataIn;
  end

  always_ff @(posedge rclk) begin
    if (stb.outClr)      dataOut <= '0;
    else if (stb.rdLoad) dataOut <= mem[rAddr];
  end
endmodule

// File: rtl/dual_clk_fifo.sv
`timescale 1ns/1ps
module dual_clk_fifo
  import dcfifo_pkg::*;
#(
  parameter int DATA_W     = 18,
  parameter int ADDR_W     = 11,
  parameter int OFF_DEF_LO = 127,
  parameter int OFF_DEF_HI = 1023
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              fwftSel,
  input  logic              offSel,
  input  logic              wen,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ld,
  input  logic              sen,
  input  logic              serIn,
  input  logic              ren,
  input  logic              rt,
  output logic [DATA_W-1:0] dataOut,
  output logic              emptyOrRdy,
  output logic              fullOrIrdy,
  output logic              halfFull,
  output logic              almostEmpty,
  output logic              almostFull
);
  fifoStb_t          stb;
  logic [ADDR_W-1:0] wAddr, rAddr;

  dcfifo_ctrl #(
    .ADDR_W(ADDR_W), .OFF_DEF_LO(OFF_DEF_LO), .OFF_DEF_HI(OFF_DEF_HI)
  ) uCtrl (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
    .fwftSel(fwftSel), .offSel(offSel), .wen(wen),
    .offIn(dataIn[ADDR_W-1:0]), .ld(ld), .sen(sen), .serIn(serIn),
    .ren(ren), .rt(rt), .stb(stb), .wAddr(wAddr), .rAddr(rAddr),
    .emptyOrRdy(emptyOrRdy), .fullOrIrdy(fullOrIrdy), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  dcfifo_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uDpath (
    .wclk(wclk), .rclk(rclk), .stb(stb), .wAddr(wAddr), .rAddr(rAddr),
    .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: tb/tb_dual_clk_fifo.sv
`timescale 1ns/1ps
module tb_dual_clk_fifo;
  localparam int DW = 18;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] PAT [8] = '{18'h00001, 18'h3FFFF, 18'h2AAAA, 18'h15555,
                                        18'h00000, 18'h1F0F0, 18'h20F0F, 18'h12345};

  logic wclk = 0, rclk = 0;
  logic mrst = 1, prst = 0, fwftSel = 0, offSel = 0;
  logic wen = 0, ld = 0, sen = 0, serIn = 0, ren = 0, rt = 0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic emptyOrRdy, fullOrIrdy, halfFull, almostEmpty, almostFull;
  int compared = 0, mismatched = 0;

  always #2.5 wclk = ~wclk;   // 200 MHz write clock
  always #3.5 rclk = ~rclk;   // unrelated read clock

  dual_clk_fifo dut (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwftSel(fwftSel),
    .offSel(offSel), .wen(wen), .dataIn(dataIn), .ld(ld), .sen(sen),
    .serIn(serIn), .ren(ren), .rt(rt), .dataOut(dataOut),
    .emptyOrRdy(emptyOrRdy), .fullOrIrdy(fullOrIrdy), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic waitR(input int n); repeat (n) @(negedge rclk); endtask
  task automatic waitW(input int n); repeat (n) @(negedge wclk); endtask

  task automatic wrOne(input logic [DW-1:0] v);
    @(negedge wclk); wen = 1; dataIn = v;
    @(negedge wclk); wen = 0;
  endtask

  task automatic wrBurst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk); wen = 1; dataIn = DW'(base + i);
    end
    @(negedge wclk); wen = 0;
  endtask

  task automatic rdPulse();
    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0;
  endtask

  task automatic rdChk(input int n, input int base, input string req);
    @(negedge rclk); ren = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      if (i == n - 1) ren = 0;
      chk(req, dataOut, DW'(base + i));
    end
  endtask

  task automatic doReset(input bit master, input bit fw, input bit os);
    @(negedge wclk); fwftSel = fw; offSel = os;
    if (master) mrst = 1; else prst = 1;
    waitR(6);
    @(negedge wclk); mrst = 0; prst = 0;
    waitR(2);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    mismatched++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int lat;
    // R1: master reset, standard mode, low defaults
    doReset(1, 0, 0);
    chk("R1 empty", emptyOrRdy, 1);
    chk("R1 full", fullOrIrdy, 0);
    chk("R1 half", halfFull, 0);
    chk("R1 ae", almostEmpty, 1);
    chk("R1 af", almostFull, 0);
    chk("R1 dout", dataOut, 0);

    // R3: read while empty is ignored
    rdPulse();
    chk("R3 underflow dout", dataOut, 0);
    chk("R3 underflow empty", emptyOrRdy, 1);

    // R2: vector table written then read back in order
    foreach (PAT[i]) wrOne(PAT[i]);
    waitR(6);
    chk("R2 not empty", emptyOrRdy, 0);
    foreach (PAT[i]) begin
      rdPulse();
      chk("R2 order", dataOut, PAT[i]);
    end
    chk("R2 empty again", emptyOrRdy, 1);

    // R12: first-word latency
    wrOne(18'h0BEEF);
    lat = 0;
    while (emptyOrRdy && lat < 10) begin @(negedge rclk); lat++; end
    chk("R12 latency within 4", (lat <= 4), 1);
    rdPulse();
    chk("R12 first word", dataOut, 18'h0BEEF);

    // R6 almost-empty at default 127
    wrBurst(127, 0); waitR(6);
    chk("R6 ae at 127", almostEmpty, 1);
    wrBurst(1, 127); waitR(6);
    chk("R6 ae at 128", almostEmpty, 0);
    // R5 half full
    wrBurst(896, 128);
    chk("R5 half at 1024", halfFull, 0);
    wrBurst(1, 1024);
    chk("R5 half at 1025", halfFull, 1);
    // R6 almost-full at DEPTH-127
    wrBurst(895, 1025);
    chk("R6 af at 1920", almostFull, 0);
    wrBurst(1, 1920);
    chk("R6 af at 1921", almostFull, 1);
    chk("R4 not full at 1921", fullOrIrdy, 0);
    wrBurst(127, 1921);
    chk("R4 full at 2048", fullOrIrdy, 1);
    wrOne(18'h2AAAA);  // R3: dropped
    chk("R3 still full", fullOrIrdy, 1);
    waitR(6);
    rdChk(DEPTH, 0, "R2 full drain");
    chk("R3 overflow word dropped", emptyOrRdy, 1);
    waitW(6);
    chk("R4 full clears", fullOrIrdy, 0);

    // R9: parallel offset load, AE=5 then AF=2040
    @(negedge wclk); ld = 1; wen = 1; dataIn = 18'd5;
    @(negedge wclk); dataIn = 18'd2040;
    @(negedge wclk); wen = 0; ld = 0;
    waitR(6);
    chk("R9 no data written", emptyOrRdy, 1);
    wrBurst(5, 100); waitR(6);
    chk("R9 ae at 5", almostEmpty, 1);
    wrBurst(1, 105); waitR(6);
    chk("R9 ae at 6", almostEmpty, 0);
    chk("R9 af at 6", almostFull, 0);
    wrBurst(2, 106);
    chk("R9 af at 8", almostFull, 1);

    // R8: partial reset keeps offsets and mode
    doReset(0, 1, 1);
    chk("R8 empty std", emptyOrRdy, 1);
    chk("R8 full std", fullOrIrdy, 0);
    chk("R8 af cleared", almostFull, 0);
    wrBurst(5, 200); waitR(6);
    chk("R8 ae kept at 5", almostEmpty, 1);
    wrBurst(1, 205); waitR(6);
    chk("R8 ae kept at 6", almostEmpty, 0);
    wrBurst(2, 206);
    chk("R8 af kept at 8", almostFull, 1);

    // R11: retransmit replays from first word
    rdChk(3, 200, "R11 before rewind");
    @(negedge rclk); rt = 1;
    @(negedge rclk); rt = 0;
    waitR(2);
    rdChk(4, 200, "R11 replay");

    // R10: serial load AE=2, AF=2044 (LSB first, AE first)
    doReset(0, 0, 0);
    @(negedge wclk); ld = 1;
    for (int i = 0; i < 2 * AW; i++) begin
      if (i > 0) @(negedge wclk);
      sen = 1;
      serIn = (i < AW) ? ((2 >> i) & 1) : ((2044 >> (i - AW)) & 1);
    end
    @(negedge wclk); sen = 0; ld = 0;
    waitR(6);
    chk("R10 no data written", emptyOrRdy, 1);
    wrBurst(2, 300); waitR(6);
    chk("R10 ae at 2", almostEmpty, 1);
    chk("R10 af at 2", almostFull, 0);
    wrBurst(1, 302); waitR(6);
    chk("R10 ae at 3", almostEmpty, 0);
    wrBurst(1, 303);
    chk("R10 af at 4", almostFull, 1);

    // R1: master reset into fall-through mode with high defaults
    doReset(1, 1, 1);
    chk("R1 fwft not valid", emptyOrRdy, 0);
    chk("R1 fwft room", fullOrIrdy, 1);
    chk("R1 fwft ae", almostEmpty, 1);
    chk("R1 fwft dout", dataOut, 0);

    // R7: fall-through behaviour
    wrOne(18'h01234); waitR(6);
    chk("R7 word falls through", dataOut, 18'h01234);
    chk("R7 valid", emptyOrRdy, 1);
    wrOne(18'h02345); wrOne(18'h03456); waitR(6);
    chk("R7 held without ren", dataOut, 18'h01234);
    rdPulse();
    chk("R7 second word", dataOut, 18'h02345);
    rdPulse();
    chk("R7 third word", dataOut, 18'h03456);
    chk("R7 still valid", emptyOrRdy, 1);
    rdPulse();
    chk("R7 drained", emptyOrRdy, 0);

    // R6: high default 1023 for both thresholds
    wrBurst(1024, 0); waitR(6); waitW(6);
    chk("R6 hi ae at 1023", almostEmpty, 1);
    chk("R7 head word", dataOut, 0);
    wrBurst(1, 1024); waitR(6);
    chk("R6 hi ae at 1024", almostEmpty, 0);
    chk("R6 hi af at 1024", almostFull, 0);
    wrBurst(1, 1025);
    chk("R6 hi af at 1025", almostFull, 1);
    chk("R5 half in fwft", halfFull, 1);
    chk("R7 room left", fullOrIrdy, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule